// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block sits beside a processor's retirement stage and turns its control-flow activity into a compact byte stream for a trace buffer. Each cycle it can see a retirement pulse for an ordinary instruction, a direct branch, an indirect branch with its 32-bit target, or an exception with its vector bits, plus a checkpoint flag. It keeps a 4-bit running count of instructions retired since the last message. On every control-flow change it emits one message byte that packs the message kind and that count. Indirect branches append their target address.

Runs of 16 or more instructions with no control-flow change are carried by a fixed rollover byte. Bytes leave through a valid/ready handshake. While bytes of an earlier message are still waiting, the block raises a stall output and the processor must hold its inputs.

Top module: `trace_msg_encoder`

## Requirements
- R1: After reset `o_tb_valid` and `o_stall` are 0 and the instruction count is 0, so a branch taken as the first event reports a count of 0.
- R2: An exception produces the byte `{1'b0, vec[2:0], cnt[3:0]}`, where `vec` is bits [4:2] of the vector offset, with no address bytes.
- R3: A direct branch produces `{1'b1, chk, 2'b00, cnt}`, where `chk` is the checkpoint flag, with no address bytes.
- R4: An indirect branch produces `{1'b1, chk, 2'b01, cnt}`, followed at once by the four target bytes, most significant first.
- R5: `cnt` equals the number of retirement pulses accepted since the previous message. A pulse in the same cycle as an event is counted. The branching or faulting instruction itself is never signalled as a retirement.
- R6: When an accepted retirement would make the count 16 with no event in that cycle, the byte 0xFF is emitted and the count restarts at 0. The rollover byte is not counted.
- R7: If a rollover and an event occur in the same cycle, 0xFF is emitted first, then the event's message with count 0.
- R8: The count clears after every message, so an event right after another event reports a count of 0.
- R9: `o_stall` is high while any byte is pending, and inputs are ignored while it is high. A byte offered with `i_tb_ready` low is held unchanged until it is taken.
- R10: When several event inputs pulse together, exception takes precedence over indirect branch, which takes precedence over direct branch.
- R11: The checkpoint flag has no effect on exception messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_retire | input | 1 | A non-branching instruction retired, including condition-failed ones |
| i_dir_branch | input | 1 | A direct branch was taken |
| i_ind_branch | input | 1 | An indirect branch was taken |
| i_ind_target | input | 32 | Target address of the indirect branch |
| i_exception | input | 1 | An exception was taken |
| i_exc_vector | input | 3 | Bits [4:2] of the exception vector offset |
| i_checkpoint | input | 1 | Branch is checkpointed |
| o_stall | output | 1 | Pending bytes; hold inputs |
| o_tb_valid | output | 1 | `o_tb_byte` holds a byte for the trace buffer |
| o_tb_byte | output | 8 | Trace byte |
| i_tb_ready | input | 1 | Trace buffer takes the byte this cycle |

## Verification
A wrong count value shows up in the low nibble of the very next message byte. A counter that misses a clear or a rollover shifts every later count, so one slip corrupts the remainder of the stream. A queue that drops, repeats or reorders bytes misaligns the whole expected byte sequence from that point on. This is most visible with indirect targets under a slow ready pattern. Inputs accepted during a stall add phantom messages or inflate a later count within one message.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;

    localparam int CNT_W      = 4;
    localparam int ADDR_BYTES = 4;
    localparam int TGT_W      = 8 * ADDR_BYTES;
    localparam int MAX_BYTES  = ADDR_BYTES + 2;
    localparam int VEC_W      = 3;

    localparam logic [7:0] ROLLOVER_BYTE = 8'hFF;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_DIRECT   = 2'd1,
        EV_INDIRECT = 2'd2,
        EV_EXCEPT   = 2'd3
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t              kind;
        logic                  chkpt;
        logic [VEC_W-1:0]      vec;
        logic [TGT_W-1:0]      target;
    } flow_event_t;

    // Exception wins over indirect, indirect over direct.
    function automatic flow_event_t decode_event(
        input logic             dir,
        input logic             ind,
        input logic             exc,
        input logic [VEC_W-1:0] vec,
        input logic             chk,
        input logic [TGT_W-1:0] tgt
    );
        flow_event_t e;
        e.vec    = vec;
        e.chkpt  = chk;
        e.target = tgt;
        if (exc)      e.kind = EV_EXCEPT;
        else if (ind) e.kind = EV_INDIRECT;
        else if (dir) e.kind = EV_DIRECT;
        else          e.kind = EV_NONE;
        return e;
    endfunction

    function automatic byte_t head_byte(
        input flow_event_t      e,
        input logic [CNT_W-1:0] cnt
    );
        byte_t b;
        case (e.kind)
            EV_EXCEPT:   b = {1'b0, e.vec, cnt};
            EV_DIRECT:   b = {1'b1, e.chkpt, 2'b00, cnt};
            EV_INDIRECT: b = {1'b1, e.chkpt, 2'b01, cnt};
            default:     b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/trace_icount.sv
module trace_icount
    import trace_enc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  logic         retire,
    input  logic         event_any,
    output logic         roll,
    output logic [W-1:0] msg_cnt
);

    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    always_comb begin
        sum     = {1'b0, cnt_q} + {{W{1'b0}}, retire};
        roll    = sum[W];
        msg_cnt = roll ? '0 : sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept) begin
            if (event_any || roll) cnt_q <= '0;
            else                   cnt_q <= sum[W-1:0];
        end
    end

    // R8: count restarts after any message
    a_r8_clear_after_msg: assert property (@(posedge clk) disable iff (rst)
        accept && event_any |=> cnt_q == '0);

    // R6: rollover restarts count
    a_r6_roll_restart: assert property (@(posedge clk) disable iff (rst)
        accept && roll |=> cnt_q == '0);

    // R5: a lone retirement advances the count by one
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        accept && retire && !event_any && !roll |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9: nothing is counted while stalled
    a_r9_frozen_when_stalled: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cnt_q));

endmodule

// File: rtl/trace_msg_pack.sv
module trace_msg_pack
    import trace_enc_pkg::*;
#(
    parameter int NADDR = ADDR_BYTES,
    parameter int NMAX  = NADDR + 2,
    localparam int LEN_W = $clog2(NMAX + 1)
) (
    input  logic                         roll,
    input  flow_event_t                  ev,
    input  logic [CNT_W-1:0]             msg_cnt,
    output logic [NMAX-1:0][7:0]         bytes,
    output logic [LEN_W-1:0]             len
);

    // group = message byte plus optional address bytes
    logic [NADDR:0][7:0] grp;
    logic [LEN_W-1:0]    grp_len;

    always_comb begin
        grp     = '0;
        grp_len = '0;
        if (ev.kind != EV_NONE) begin
            grp[0]  = head_byte(ev, msg_cnt);
            grp_len = LEN_W'(1);
            if (ev.kind == EV_INDIRECT) begin
                for (int a = 0; a < NADDR; a++) begin
                    grp[a+1] = ev.target[8*(NADDR-1-a) +: 8];
                end
                grp_len = LEN_W'(NADDR + 1);
            end
        end
    end

    always_comb begin
        bytes = '0;
        if (roll) begin
            bytes[0] = ROLLOVER_BYTE;
            for (int i = 0; i <= NADDR; i++) bytes[i+1] = grp[i];
            len = grp_len + LEN_W'(1);
        end else begin
            for (int i = 0; i <= NADDR; i++) bytes[i] = grp[i];
            len = grp_len;
        end
    end

endmodule

// File: rtl/trace_byte_queue.sv
module trace_byte_queue #(
    parameter int DEPTH = 6,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [DEPTH-1:0][7:0]  load_bytes,
    input  logic [LEN_W-1:0]       load_len,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [7:0]             out_byte,
    output logic                   busy
);

    logic [DEPTH-1:0][7:0] q;
    logic [LEN_W-1:0]      pend;
    logic                  pop;

    assign out_valid = (pend != '0);
    assign busy      = out_valid;
    assign out_byte  = q[0];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            pend <= '0;
        end else if (load) begin
            q    <= load_bytes;
            pend <= load_len;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
            q[DEPTH-1] <= '0;
            pend       <= pend - LEN_W'(1);
        end
    end

    // R9: a message is only loaded into an empty queue
    a_r9_load_when_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> pend == '0);

    // R9: an offered byte is held until taken
    a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    // R4: every load carries at least one byte and fits the queue
    a_r4_load_len_ok: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_len != '0) && (load_len <= LEN_W'(DEPTH)));

endmodule

// File: rtl/trace_msg_encoder.sv
module trace_msg_encoder
    import trace_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_retire,
    input  logic              i_dir_branch,
    input  logic              i_ind_branch,
    input  logic [TGT_W-1:0]  i_ind_target,
    input  logic              i_exception,
    input  logic [VEC_W-1:0]  i_exc_vector,
    input  logic              i_checkpoint,
    output logic              o_stall,
    output logic              o_tb_valid,
    output logic [7:0]        o_tb_byte,
    input  logic              i_tb_ready
);

    localparam int LEN_W = $clog2(MAX_BYTES + 1);

    flow_event_t                ev;
    logic                       accept;
    logic                       event_any;
    logic                       roll;
    logic [CNT_W-1:0]           msg_cnt;
    logic [MAX_BYTES-1:0][7:0]  pk_bytes;
    logic [LEN_W-1:0]           pk_len;
    logic                       load;
    logic                       busy;

    assign ev = decode_event(i_dir_branch, i_ind_branch, i_exception,
                             i_exc_vector, i_checkpoint, i_ind_target);
    assign event_any = (ev.kind != EV_NONE);
    assign accept    = !busy;
    assign load      = accept && (event_any || roll);
    assign o_stall   = busy;

    trace_icount #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .retire    (i_retire),
        .event_any (event_any),
        .roll      (roll),
        .msg_cnt   (msg_cnt)
    );

    trace_msg_pack #(.NADDR(ADDR_BYTES), .NMAX(MAX_BYTES)) u_pack (
        .roll    (roll),
        .ev      (ev),
        .msg_cnt (msg_cnt),
        .bytes   (pk_bytes),
        .len     (pk_len)
    );

    trace_byte_queue #(.DEPTH(MAX_BYTES)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_bytes (pk_bytes),
        .load_len   (pk_len),
        .out_ready  (i_tb_ready),
        .out_valid  (o_tb_valid),
        .out_byte   (o_tb_byte),
        .busy       (busy)
    );

    // R9: any accepted message is offered on the next cycle with stall raised
    a_r9_stall_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> o_stall && o_tb_valid);

    // R1: idle with nothing to send means no stall
    a_r1_no_stall_when_empty: assert property (@(posedge clk) disable iff (rst)
        !o_tb_valid |-> !o_stall);

endmodule

// File: tb/tb_trace_msg_encoder.sv
module tb_trace_msg_encoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        i_retire, i_dir_branch, i_ind_branch, i_exception, i_checkpoint;
    logic [31:0] i_ind_target;
    logic [2:0]  i_exc_vector;
    logic        o_stall, o_tb_valid, i_tb_ready;
    logic [7:0]  o_tb_byte;

    always #5 clk = ~clk;

    trace_msg_encoder dut (
        .clk(clk), .rst(rst),
        .i_retire(i_retire), .i_dir_branch(i_dir_branch),
        .i_ind_branch(i_ind_branch), .i_ind_target(i_ind_target),
        .i_exception(i_exception), .i_exc_vector(i_exc_vector),
        .i_checkpoint(i_checkpoint),
        .o_stall(o_stall), .o_tb_valid(o_tb_valid), .o_tb_byte(o_tb_byte),
        .i_tb_ready(i_tb_ready)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    int    rmode  = 0;
    int    cyc    = 0;
    int    exp_cnt = 0;
    bit [7:0] exp_q [0:4095];
    string    exp_tag [0:4095];
    int    head = 0, tail = 0;

    function automatic void push(input bit [7:0] b, input string tag);
        exp_q[tail % 4096]   = b;
        exp_tag[tail % 4096] = tag;
        tail++;
    endfunction

    function automatic void check(input bit ok, input string tag,
                                  input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    // Monitor: chooses ready, compares each transferred byte
    always @(negedge clk) begin
        bit r;
        cyc++;
        case (rmode)
            0:       r = 1'b1;
            1:       r = cyc[0];
            default: r = (cyc % 3 == 0);
        endcase
        i_tb_ready = r;
        if (!rst && o_tb_valid && r) begin
            if (head == tail) begin
                check(1'b0, "R9 unexpected byte", o_tb_byte, 0);
            end else begin
                check(o_tb_byte == exp_q[head % 4096], exp_tag[head % 4096],
                      o_tb_byte, exp_q[head % 4096]);
                head++;
            end
        end
    end

    // Drive one accepted cycle and update the reference model
    task automatic step(input bit ret, input bit dir, input bit ind, input bit exc,
                        input bit [2:0] vec, input bit chk, input bit [31:0] tgt);
        int sum, mc;
        @(negedge clk);
        while (o_stall) @(negedge clk);
        i_retire = ret; i_dir_branch = dir; i_ind_branch = ind;
        i_exception = exc; i_exc_vector = vec; i_checkpoint = chk;
        i_ind_target = tgt;
        sum = exp_cnt + int'(ret);
        if (sum == 16) begin
            push(8'hFF, (dir | ind | exc) ? "R7 rollover first" : "R6 rollover");
            mc = 0;
        end else begin
            mc = sum;
        end
        if (exc) begin
            push({1'b0, vec, mc[3:0]}, (dir | ind) ? "R10 exception wins" : "R2 exception");
        end else if (ind) begin
            push({1'b1, chk, 2'b01, mc[3:0]}, dir ? "R10 indirect wins" : "R4 indirect");
            for (int a = 3; a >= 0; a--) push(tgt[8*a +: 8], "R4 target byte");
        end else if (dir) begin
            push({1'b1, chk, 2'b00, mc[3:0]}, "R3 direct");
        end
        if (dir | ind | exc || sum == 16) exp_cnt = 0;
        else exp_cnt = sum;
    endtask

    task automatic retires(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 3'd0, 0, 32'h0);
    endtask

    task automatic drain();
        step(0, 0, 0, 0, 3'd0, 0, 32'h0);
        while (head != tail || o_tb_valid) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        i_retire = 0; i_dir_branch = 0; i_ind_branch = 0; i_exception = 0;
        i_exc_vector = 0; i_checkpoint = 0; i_ind_target = 0; i_tb_ready = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(o_tb_valid == 1'b0, "R1 valid after reset", o_tb_valid, 0);
        check(o_stall == 1'b0, "R1 stall after reset", o_stall, 0);
        // R1: first branch reports count 0
        step(0, 1, 0, 0, 3'd0, 0, 32'h0);
        drain();

        // R3/R5/R6: direct branches after 0..20 retirements
        rmode = 0;
        for (int k = 0; k <= 20; k++) begin
            retires(k);
            step(0, 1, 0, 0, 3'd0, k[0], 32'h0);
        end
        drain();

        // R2/R11: every vector, checkpoint flag set
        rmode = 1;
        for (int v = 0; v < 8; v++) begin
            retires(v * 2);
            step(0, 0, 0, 1, v[2:0], 1, 32'h0);
        end
        drain();

        // R4: indirect branches with target bytes under slow ready
        for (int k = 0; k < 6; k++) begin
            retires(k + 3);
            step(0, 0, 1, 0, 3'd0, k[0], 32'h1234_5678 ^ (k * 32'h1111_1111));
        end
        drain();

        rmode = 2;
        // R8: back-to-back events give count 0
        step(0, 1, 0, 0, 3'd0, 0, 32'h0);
        step(0, 0, 0, 1, 3'd5, 0, 32'h0);
        step(0, 0, 1, 0, 3'd0, 1, 32'hDEAD_BEEF);
        step(0, 1, 0, 0, 3'd0, 1, 32'h0);
        // R10: simultaneous events
        retires(2);
        step(0, 1, 1, 1, 3'd6, 1, 32'hAAAA_5555);
        step(1, 1, 1, 0, 3'd0, 0, 32'h0102_0304);
        // R7: rollover in the same cycle as an event
        retires(15);
        step(1, 1, 0, 0, 3'd0, 0, 32'h0);
        retires(15);
        step(1, 0, 1, 0, 3'd0, 1, 32'hCAFE_F00D);
        // R5: retirement in the event cycle is counted
        retires(5);
        step(1, 1, 0, 0, 3'd0, 0, 32'h0);
        // R6: exactly 16 and 32 retirements
        retires(16);
        step(0, 1, 0, 0, 3'd0, 0, 32'h0);
        retires(32);
        step(0, 0, 0, 1, 3'd7, 0, 32'h0);
        // R9: inputs driven during a stall are ignored
        retires(4);
        step(0, 0, 1, 0, 3'd0, 0, 32'h7654_3210);
        @(negedge clk);
        if (o_stall) begin
            i_retire = 1; i_dir_branch = 1; i_exception = 1; i_exc_vector = 3'd3;
        end
        step(0, 0, 0, 0, 3'd0, 0, 32'h0);
        retires(3);
        step(0, 1, 0, 0, 3'd0, 0, 32'h0);

        rmode = 0;
        drain();
        check(head == tail, "R9 all bytes delivered", tail - head, 0);
        check(o_stall == 1'b0, "R9 stall released", o_stall, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule